// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between the execute stage of a 32-bit core and a data memory that is byte-addressed but word-wide. For each memory instruction it takes the 6-bit opcode, the base register value, the raw 16-bit offset field and the store source register. It forms the effective address and turns it into a word-aligned memory address. For stores it produces per-lane write strobes and lane-steered write data. For loads it picks the addressed byte or halfword out of the returned word and extends it to a full register value. Lane order is big-endian: the byte at the lowest address occupies the most significant lane of the word.

The block has two registered stages. One cycle after a request is accepted, the memory-side outputs appear: address, strobes, write data, read enable, address-error flag and invalid-opcode flag. The memory answers that address in the same cycle with `mem_rdata`. One cycle later, the register-file side presents the load result and a write enable. The load-upper-immediate opcode uses the same result path but never touches memory. A halfword or word access that is not naturally aligned is stopped: it raises an address error, produces no strobes and no read, and does not write the register file.

Top module: `be_ldst_aligner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is zero.
- R2: One cycle after an accepted request (`req_valid` high), `mem_addr` equals `req_base` plus the sign-extended `req_imm`, with its two low bits cleared.
- R3: Byte loads read byte offset o (the low two bits of the effective address) from `mem_rdata` bits [31-8o -: 8]. Opcode 0x20 sign-extends the byte and opcode 0x24 zero-extends it. The result appears on `rf_wdata`, with `rf_we` high, two cycles after the request.
- R4: Halfword loads take `mem_rdata[31:16]` when address bit 1 is clear and `mem_rdata[15:0]` when it is set. Opcode 0x21 sign-extends the halfword and opcode 0x25 zero-extends it. Timing is the same as in R3.
- R5: The word load, opcode 0x23, returns `mem_rdata` unchanged, with the timing of R3. Every load raises `mem_rd` together with the address and leaves `mem_strb` at zero.
- R6: Stores assert strobe bit 3-o for byte offset o. Opcode 0x28 (byte) asserts one lane and places `req_rt[7:0]` in every lane. Opcode 0x29 (halfword) asserts 4'b1100 at offset 0 or 4'b0011 at offset 2, with `req_rt[15:0]` in both halves. Opcode 0x2b (word) asserts 4'b1111 and passes `req_rt` unchanged. Stores never raise `rf_we`.
- R7: A halfword access with address bit 0 set, or a word access with either low address bit set, raises `addr_err` one cycle after the request. Such an access drives zero strobes and no `mem_rd`, and no `rf_we` follows it. A byte access at any offset is never an error.
- R8: Opcode 0x0f writes `{req_imm, 16'h0000}` to `rf_wdata` with `rf_we` two cycles after the request. It raises neither `mem_rd` nor any strobe.
- R9: Any other opcode raises `bad_op` one cycle after the request, with no strobe, no `mem_rd`, no `addr_err` and no later `rf_we`.
- R10: While `req_valid` is low, the next cycle shows no strobe, no `mem_rd`, no `addr_err` and no `bad_op`, and no `rf_we` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Instruction opcode |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Raw offset / immediate field |
| req_rt | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word returned by memory for `mem_addr` |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_strb | output | 4 | Byte-lane write strobes, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rd | output | 1 | Read enable for loads |
| addr_err | output | 1 | Misaligned halfword/word access |
| bad_op | output | 1 | Opcode not handled by this block |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 32 | Extended load or upper-immediate result |

## Verification
Memory-side results (address, strobes, write data, read enable and the two flags) are due one clock after the edge that takes the request. Register-side results (`rf_we`, `rf_wdata`) are due one clock after that. Each scenario task drives its request on a falling edge. It checks the memory-side outputs on the next falling edge, when it also drops `req_valid`, and the register-side outputs on the falling edge after that, so every sample is taken half a period away from the edge that updates it. The memory model answers combinationally from `mem_addr`, so the returned word belongs to the same cycle as the address.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;
  localparam int XLEN  = 32;
  localparam int NLANE = XLEN / 8;
  localparam int OFFW  = $clog2(NLANE);

  localparam logic [5:0] OPC_LDB  = 6'h20;
  localparam logic [5:0] OPC_LDH  = 6'h21;
  localparam logic [5:0] OPC_LDW  = 6'h23;
  localparam logic [5:0] OPC_LDBU = 6'h24;
  localparam logic [5:0] OPC_LDHU = 6'h25;
  localparam logic [5:0] OPC_STB  = 6'h28;
  localparam logic [5:0] OPC_STH  = 6'h29;
  localparam logic [5:0] OPC_STW  = 6'h2b;
  localparam logic [5:0] OPC_UPI  = 6'h0f;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      known;
    logic      rd;
    logic      wr;
    logic      upper;
    logic      sx;
    acc_size_e size;
  } op_info_t;
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
  import ldst_align_pkg::*;
(
  input  logic [5:0] op_i,
  output op_info_t   info_o
);
  always_comb begin
    info_o = '{known: 1'b0, rd: 1'b0, wr: 1'b0, upper: 1'b0, sx: 1'b0, size: ACC_BYTE};
    case (op_i)
      OPC_LDB:  info_o = '{known: 1'b1, rd: 1'b1, wr: 1'b0, upper: 1'b0, sx: 1'b1, size: ACC_BYTE};
      OPC_LDBU: info_o = '{known: 1'b1, rd: 1'b1, wr: 1'b0, upper: 1'b0, sx: 1'b0, size: ACC_BYTE};
      OPC_LDH:  info_o = '{known: 1'b1, rd: 1'b1, wr: 1'b0, upper: 1'b0, sx: 1'b1, size: ACC_HALF};
      OPC_LDHU: info_o = '{known: 1'b1, rd: 1'b1, wr: 1'b0, upper: 1'b0, sx: 1'b0, size: ACC_HALF};
      OPC_LDW:  info_o = '{known: 1'b1, rd: 1'b1, wr: 1'b0, upper: 1'b0, sx: 1'b0, size: ACC_WORD};
      OPC_STB:  info_o = '{known: 1'b1, rd: 1'b0, wr: 1'b1, upper: 1'b0, sx: 1'b0, size: ACC_BYTE};
      OPC_STH:  info_o = '{known: 1'b1, rd: 1'b0, wr: 1'b1, upper: 1'b0, sx: 1'b0, size: ACC_HALF};
      OPC_STW:  info_o = '{known: 1'b1, rd: 1'b0, wr: 1'b1, upper: 1'b0, sx: 1'b0, size: ACC_WORD};
      OPC_UPI:  info_o = '{known: 1'b1, rd: 1'b0, wr: 1'b0, upper: 1'b1, sx: 1'b0, size: ACC_BYTE};
      default:  ;
    endcase
  end
endmodule

// File: rtl/lsa_agen.sv
module lsa_agen
  import ldst_align_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMM_W = 16
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  acc_size_e        size_i,
  output logic [AW-1:0]    word_addr_o,
  output logic [OFFW-1:0]  off_o,
  output logic             mis_o
);
  logic [AW-1:0] ea;

  always_comb begin
    ea          = base_i + {{(AW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    word_addr_o = {ea[AW-1:OFFW], {OFFW{1'b0}}};
    off_o       = ea[OFFW-1:0];
    case (size_i)
      ACC_HALF: mis_o = ea[0];
      ACC_WORD: mis_o = |ea[OFFW-1:0];
      default:  mis_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import ldst_align_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFFW-1:0]  off_i,
  input  logic [XLEN-1:0]  rt_i,
  output logic [NLANE-1:0] strb_o,
  output logic [XLEN-1:0]  wdata_o
);
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    localparam int POS = NLANE - 1 - l;
    logic       hit;
    logic [7:0] lane;

    always_comb begin
      case (size_i)
        ACC_BYTE: begin
          hit  = (off_i == OFFW'(POS));
          lane = rt_i[7:0];
        end
        ACC_HALF: begin
          hit  = (off_i[OFFW-1] == POS[OFFW-1]);
          lane = rt_i[8*(l%2) +: 8];
        end
        default: begin
          hit  = 1'b1;
          lane = rt_i[8*l +: 8];
        end
      endcase
    end

    assign strb_o[l]         = hit;
    assign wdata_o[8*l +: 8] = lane;
  end
endmodule

// File: rtl/lsa_load_pick.sv
module lsa_load_pick
  import ldst_align_pkg::*;
(
  input  logic [XLEN-1:0] word_i,
  input  logic [OFFW-1:0] off_i,
  input  acc_size_e       size_i,
  input  logic            sx_i,
  output logic [XLEN-1:0] val_o
);
  logic [XLEN-1:0] bsh, hsh;
  logic [7:0]      b;
  logic [15:0]     h;

  always_comb begin
    bsh = word_i >> (8 * (NLANE - 1 - int'(off_i)));
    hsh = word_i >> (16 * (1 - int'(off_i[OFFW-1])));
    b   = bsh[7:0];
    h   = hsh[15:0];
    case (size_i)
      ACC_BYTE: val_o = {{(XLEN-8){sx_i & b[7]}}, b};
      ACC_HALF: val_o = {{(XLEN-16){sx_i & h[15]}}, h};
      default:  val_o = word_i;
    endcase
  end
endmodule

// File: rtl/be_ldst_aligner.sv
module be_ldst_aligner
  import ldst_align_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [5:0]       req_op,
  input  logic [AW-1:0]    req_base,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [XLEN-1:0]  req_rt,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic [NLANE-1:0] mem_strb,
  output logic [XLEN-1:0]  mem_wdata,
  output logic             mem_rd,
  output logic             addr_err,
  output logic             bad_op,
  output logic             rf_we,
  output logic [XLEN-1:0]  rf_wdata
);
  op_info_t         info;
  logic [AW-1:0]    waddr;
  logic [OFFW-1:0]  off;
  logic             mis;
  logic [NLANE-1:0] strb_c;
  logic [XLEN-1:0]  wdata_c;
  logic [XLEN-1:0]  picked;
  logic             touches, ok_acc;

  // stage-1 bookkeeping for the load path
  logic             s1_ld, s1_upi, s1_sx;
  logic [OFFW-1:0]  s1_off;
  acc_size_e        s1_size;
  logic [IMM_W-1:0] s1_imm;

  lsa_decode u_dec (.op_i(req_op), .info_o(info));

  lsa_agen #(.AW(AW), .IMM_W(IMM_W)) u_agen (
    .base_i(req_base), .imm_i(req_imm), .size_i(info.size),
    .word_addr_o(waddr), .off_o(off), .mis_o(mis)
  );

  lsa_store_steer u_st (
    .size_i(info.size), .off_i(off), .rt_i(req_rt),
    .strb_o(strb_c), .wdata_o(wdata_c)
  );

  lsa_load_pick u_ld (
    .word_i(mem_rdata), .off_i(s1_off), .size_i(s1_size), .sx_i(s1_sx),
    .val_o(picked)
  );

  assign touches = req_valid & (info.rd | info.wr);
  assign ok_acc  = touches & ~mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_strb  <= '0;
      mem_wdata <= '0;
      mem_rd    <= 1'b0;
      addr_err  <= 1'b0;
      bad_op    <= 1'b0;
      s1_ld     <= 1'b0;
      s1_upi    <= 1'b0;
      s1_sx     <= 1'b0;
      s1_off    <= '0;
      s1_size   <= ACC_BYTE;
      s1_imm    <= '0;
    end else begin
      if (req_valid) mem_addr <= waddr;
      mem_strb  <= (ok_acc & info.wr) ? strb_c : '0;
      mem_wdata <= (ok_acc & info.wr) ? wdata_c : '0;
      mem_rd    <= ok_acc & info.rd;
      addr_err  <= touches & mis;
      bad_op    <= req_valid & ~info.known;
      s1_ld     <= ok_acc & info.rd;
      s1_upi    <= req_valid & info.upper;
      s1_sx     <= info.sx;
      s1_off    <= off;
      s1_size   <= info.size;
      s1_imm    <= req_imm;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      rf_wdata <= '0;
    end else begin
      rf_we <= s1_ld | s1_upi;
      if (s1_upi)     rf_wdata <= {s1_imm, {(XLEN-IMM_W){1'b0}}};
      else if (s1_ld) rf_wdata <= picked;
    end
  end

  // R7: a flagged misalignment reaches neither memory port
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (mem_strb == '0 && !mem_rd));

  // R7: no register write follows an address error
  a_r7_no_wb: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> !rf_we);

  // R9: an unknown opcode is silent on the memory side
  a_r9_bad_quiet: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> (mem_strb == '0 && !mem_rd && !addr_err));

  // R9: no register write follows an unknown opcode
  a_r9_no_wb: assert property (@(posedge clk) disable iff (rst)
    bad_op |=> !rf_we);

  // R6: strobes cover one lane, an aligned half, or the whole word
  a_r6_strb_shape: assert property (@(posedge clk) disable iff (rst)
    ($countones(mem_strb) == 2) |-> (mem_strb == 4'b1100 || mem_strb == 4'b0011));

  a_r6_no_three: assert property (@(posedge clk) disable iff (rst)
    $countones(mem_strb) != 3);

  // R6: a store never produces a register write
  a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
    (mem_strb != '0) |=> !rf_we);

  // R5 / R8: a write-back is preceded by a read or an upper-immediate
  a_r8_wb_source: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($past(mem_rd) || $past(s1_upi)));

  // R10: an idle cycle leaves the memory side quiet
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (mem_strb == '0 && !mem_rd && !addr_err && !bad_op));
endmodule

// File: tb/be_ldst_aligner_bench.sv
module be_ldst_aligner_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [5:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_imm = '0;
  logic [31:0] req_rt = '0;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic [3:0]  mem_strb;
  logic [31:0] mem_wdata;
  logic        mem_rd, addr_err, bad_op, rf_we;
  logic [31:0] rf_wdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memw(input logic [31:0] a);
    return {8'h81, 8'h7E, 8'hC3, 8'h3C} ^ {4{a[9:2]}};
  endfunction

  assign mem_rdata = memw(mem_addr);

  be_ldst_aligner u_be_ldst_aligner (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_imm(req_imm), .req_rt(req_rt),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_strb(mem_strb),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .addr_err(addr_err),
    .bad_op(bad_op), .rf_we(rf_we), .rf_wdata(rf_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] i);
    return b + {{16{i[15]}}, i};
  endfunction

  // drive on a falling edge; return on the falling edge after the taking edge
  task automatic issue(input logic [5:0] op, input logic [31:0] b,
                       input logic [15:0] i, input logic [31:0] rt);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = b; req_imm = i; req_rt = rt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_load(input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] i, input string tag);
    logic [31:0] ea, w, sh, exp;
    ea = ea_of(b, i);
    w  = memw({ea[31:2], 2'b00});
    case (op)
      6'h20: begin sh = w >> (8*(3-ea[1:0]));  exp = {{24{sh[7]}}, sh[7:0]}; end
      6'h24: begin sh = w >> (8*(3-ea[1:0]));  exp = {24'h0, sh[7:0]}; end
      6'h21: begin sh = ea[1] ? w : w >> 16;    exp = {{16{sh[15]}}, sh[15:0]}; end
      6'h25: begin sh = ea[1] ? w : w >> 16;    exp = {16'h0, sh[15:0]}; end
      default: begin sh = w; exp = w; end
    endcase
    issue(op, b, i, 32'hDEAD_BEEF);
    chk({tag, " R2 addr"}, mem_addr, {ea[31:2], 2'b00});
    chk({tag, " R5 rd"}, {31'h0, mem_rd}, 32'h1);
    chk({tag, " R5 strb"}, {28'h0, mem_strb}, 32'h0);
    @(negedge clk);
    chk({tag, " we"}, {31'h0, rf_we}, 32'h1);
    chk({tag, " data"}, rf_wdata, exp);
  endtask

  task automatic do_store(input logic [5:0] op, input logic [31:0] b, input logic [15:0] i,
                          input logic [31:0] rt, input logic [3:0] es, input logic [31:0] ew,
                          input string tag);
    logic [31:0] ea;
    ea = ea_of(b, i);
    issue(op, b, i, rt);
    chk({tag, " R2 addr"}, mem_addr, {ea[31:2], 2'b00});
    chk({tag, " R6 strb"}, {28'h0, mem_strb}, {28'h0, es});
    chk({tag, " R6 wdata"}, mem_wdata, ew);
    chk({tag, " R6 rd"}, {31'h0, mem_rd}, 32'h0);
    @(negedge clk);
    chk({tag, " R6 no we"}, {31'h0, rf_we}, 32'h0);
  endtask

  task automatic do_misalign(input logic [5:0] op, input logic [31:0] b,
                             input logic [15:0] i, input string tag);
    issue(op, b, i, 32'h1234_5678);
    chk({tag, " R7 err"}, {31'h0, addr_err}, 32'h1);
    chk({tag, " R7 strb"}, {28'h0, mem_strb}, 32'h0);
    chk({tag, " R7 rd"}, {31'h0, mem_rd}, 32'h0);
    @(negedge clk);
    chk({tag, " R7 no we"}, {31'h0, rf_we}, 32'h0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 addr", mem_addr, 32'h0);
    chk("R1 strb", {28'h0, mem_strb}, 32'h0);
    chk("R1 wdata", mem_wdata, 32'h0);
    chk("R1 flags", {28'h0, mem_rd, addr_err, bad_op, rf_we}, 32'h0);
    chk("R1 rfdata", rf_wdata, 32'h0);
  endtask

  task automatic t_byte_loads();
    for (int o = 0; o < 4; o++) begin
      do_load(6'h20, 32'h0000_0100, 16'(o), "R3 lb");
      do_load(6'h24, 32'h0000_0100, 16'(o), "R3 lbu");
    end
    do_load(6'h20, 32'h0000_0210, 16'hFFF5, "R3 lb negoff");
  endtask

  task automatic t_half_word_loads();
    do_load(6'h21, 32'h0000_0104, 16'h0000, "R4 lh off0");
    do_load(6'h21, 32'h0000_0104, 16'h0002, "R4 lh off2");
    do_load(6'h25, 32'h0000_0104, 16'h0002, "R4 lhu off2");
    do_load(6'h25, 32'h0000_0200, 16'hFFFE, "R4 lhu negoff");
    do_load(6'h21, 32'h0000_0180, 16'h0000, "R4 lh pos");
    do_load(6'h23, 32'h0000_0100, 16'h0008, "R5 lw");
    do_load(6'h23, 32'h0000_0300, 16'hFFFC, "R5 lw negoff");
  endtask

  task automatic t_stores();
    do_store(6'h28, 32'h40, 16'h0, 32'hAABB_CCDD, 4'b1000, 32'hDDDD_DDDD, "R6 sb o0");
    do_store(6'h28, 32'h40, 16'h1, 32'hAABB_CCDD, 4'b0100, 32'hDDDD_DDDD, "R6 sb o1");
    do_store(6'h28, 32'h40, 16'h2, 32'h0000_0011, 4'b0010, 32'h1111_1111, "R6 sb o2");
    do_store(6'h28, 32'h40, 16'h3, 32'h0000_0022, 4'b0001, 32'h2222_2222, "R6 sb o3");
    do_store(6'h29, 32'h40, 16'h0, 32'hAABB_CCDD, 4'b1100, 32'hCCDD_CCDD, "R6 sh o0");
    do_store(6'h29, 32'h40, 16'h2, 32'h1234_5678, 4'b0011, 32'h5678_5678, "R6 sh o2");
    do_store(6'h2b, 32'h48, 16'hFFFC, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D, "R6 sw");
  endtask

  task automatic t_misalign();
    do_misalign(6'h21, 32'h100, 16'h1, "R7 lh odd");
    do_misalign(6'h25, 32'h100, 16'h3, "R7 lhu odd");
    do_misalign(6'h23, 32'h100, 16'h2, "R7 lw o2");
    do_misalign(6'h2b, 32'h101, 16'h0, "R7 sw o1");
    do_misalign(6'h29, 32'h100, 16'hFFFF, "R7 sh negodd");
    issue(6'h24, 32'h100, 16'h3, 32'h0);
    chk("R7 byte never err", {31'h0, addr_err}, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_upper();
    issue(6'h0f, 32'h0000_0104, 16'hBEEF, 32'h0);
    chk("R8 no rd", {31'h0, mem_rd}, 32'h0);
    chk("R8 no strb", {28'h0, mem_strb}, 32'h0);
    @(negedge clk);
    chk("R8 we", {31'h0, rf_we}, 32'h1);
    chk("R8 data", rf_wdata, 32'hBEEF_0000);
  endtask

  task automatic t_bad_op();
    issue(6'h22, 32'h100, 16'h0, 32'h0);
    chk("R9 flag", {31'h0, bad_op}, 32'h1);
    chk("R9 quiet", {28'h0, mem_rd, addr_err, mem_strb != 4'h0, 1'b0}, 32'h0);
    @(negedge clk);
    chk("R9 no we", {31'h0, rf_we}, 32'h0);
    issue(6'h00, 32'h100, 16'h0, 32'h0);
    chk("R9 flag op0", {31'h0, bad_op}, 32'h1);
    @(negedge clk);
  endtask

  task automatic t_idle();
    do_store(6'h2b, 32'h80, 16'h0, 32'h0F0F_0F0F, 4'b1111, 32'h0F0F_0F0F, "R10 prior");
    @(negedge clk);
    req_valid = 1'b0; req_op = 6'h2b; req_base = 32'h80; req_imm = '0;
    @(negedge clk);
    chk("R10 strb", {28'h0, mem_strb}, 32'h0);
    chk("R10 flags", {29'h0, mem_rd, addr_err, bad_op}, 32'h0);
    req_op = 6'h23;
    @(negedge clk);
    chk("R10 no we", {31'h0, rf_we}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_byte_loads();
    t_half_word_loads();
    t_stores();
    t_misalign();
    t_upper();
    t_bad_op();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule